// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a system watchdog with a small byte-addressed register file. Software programs a 10-bit initial tick count, restarts the countdown with a write to the reload location, and can halt or release counting through a control bit. The live count can be read back at any time. Counting advances once per cycle in which the tick-enable input is high. The surrounding logic pulses this input at the chosen tick interval, nominally 0.6 s of real time.

Expiry happens in two stages. When the count runs out the first time, the block raises a sticky timeout flag, pulses an interrupt and restarts from the initial value. If it runs out again while that flag is still set, it raises a second-timeout flag and requests a system reset for one cycle. A no-reboot gate blocks that request. A hardware lock input can hold the gate set. All status flags are sticky and are cleared by writing one to them. A boot flag records whether the previous reset came from the watchdog.

Top module: `wdog2_top`

## Requirements
- R1: After reset the halt bit (control word at 0x08, bit 11) and the no-reboot bit (same word, bit 0) are both 1, so the control word reads 0x0801. The initial-value register (0x12) reads 0x0004, the count (0x00, bits 9:0) reads 4, and the timeout flag (0x04 bit 3) and the second-timeout flag (0x06 bit 1) read 0.
- R2: Any write to 0x00 loads the count with bits 9:0 of the initial-value register, whatever data is written.
- R3: A write to 0x12 whose bits 9:0 are below 4 is ignored and the register keeps its old value. Any other write stores all 16 bits, and they read back unchanged.
- R4: With the halt bit 0, the count drops by one on every cycle in which tick_en is high and holds when tick_en is low. With the halt bit 1 the count never drops. The halt bit reads back as written.
- R5: A reload write while halted still loads the count, and no decrement follows while halted.
- R6: A tick that finds the count at 0 is an expiry. If the timeout flag is clear, the expiry sets that flag, drives irq high for exactly one cycle and reloads the count from the initial value. All three changes are visible on the cycle after the expiry edge.
- R7: An expiry while the timeout flag is set sets the second-timeout flag, reloads the count, and drives rst_req high for exactly one cycle when the no-reboot gate is 0.
- R8: When the effective no-reboot gate is 1, rst_req stays low on a second expiry, and the second-timeout flag is still set.
- R9: While noreboot_lock is high, the no-reboot bit reads 1 and acts as 1, even after software writes it to 0. Once the lock drops, the stored value shows again.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it set. An expiry that sets the timeout flag in the same cycle as a clear of that flag wins.
- R11: The boot flag (0x06 bit 2) takes the value of boot_src during reset. It is cleared by writing 1 to it.
- R12: A reload write in the same cycle as a tick loads the initial value, and no decrement is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle tick strobe that advances the countdown |
| boot_src | input | 1 | High when the reset being applied was caused by the watchdog |
| noreboot_lock | input | 1 | Hardware lock forcing the no-reboot gate to 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the register being read or written |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq | output | 1 | One-cycle pulse on the first expiry |
| rst_req | output | 1 | One-cycle system reset request on the second expiry |

## Verification
The hardest conditions to reach are those where two events land on the same edge: an expiry together with a write that clears the timeout flag, and a tick together with a reload write. Ordinary sequential stimulus never produces these. The bench first runs the count down to exactly zero with a known number of tick cycles. It then drives tick_en and the register write in the same cycle, so both reach the same edge. The no-reboot path is reached only after a full pair of expiries with the gate set, and it is compared against an identical pair with the gate clear.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  // Byte offsets; software decodes these, so they are fixed.
  localparam logic [ADDR_W-1:0] A_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] A_STS1   = 5'h04;
  localparam logic [ADDR_W-1:0] A_STS2   = 5'h06;
  localparam logic [ADDR_W-1:0] A_CTL    = 5'h08;
  localparam logic [ADDR_W-1:0] A_INIT   = 5'h12;

  // Field positions
  localparam int B_TMO  = 3;   // status word 1
  localparam int B_SEC  = 1;   // status word 2
  localparam int B_BOOT = 2;   // status word 2
  localparam int B_HALT = 11;  // control word
  localparam int B_NRB  = 0;   // control word

  // Accept an initial value only at or above the floor.
  function automatic logic init_ok(input int unsigned val, input int unsigned floor_v);
    return val >= floor_v;
  endfunction

  // One step of the countdown: reload wins, an expiry restarts, a tick drops by one.
  function automatic int unsigned count_step(input int unsigned cur,
                                             input int unsigned start,
                                             input logic reload,
                                             input logic go);
    if (reload) return start;
    if (go && cur == 0) return start;
    if (go) return cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/wdog2_cfg.sv
module wdog2_cfg
  import wdog2_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MIN_INIT = 4,
  parameter int RST_INIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lock,
  input  logic [CNT_W-1:0]  count,
  input  logic              tmo_flag,
  input  logic              sec_flag,
  input  logic              boot_flag,
  output logic              halt,
  output logic              nrb_eff,
  output logic [CNT_W-1:0]  init_val,
  output logic              reload_wr,
  output logic              clr_tmo,
  output logic              clr_sec,
  output logic              clr_boot,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] init_q;
  logic              halt_q;
  logic              nrb_q;
  logic              wr_init, wr_ctl, wr_sts1, wr_sts2;

  assign wr_init   = wr_en && (addr == A_INIT);
  assign wr_ctl    = wr_en && (addr == A_CTL);
  assign wr_sts1   = wr_en && (addr == A_STS1);
  assign wr_sts2   = wr_en && (addr == A_STS2);
  assign reload_wr = wr_en && (addr == A_RELOAD);

  assign clr_tmo  = wr_sts1 && wdata[B_TMO];
  assign clr_sec  = wr_sts2 && wdata[B_SEC];
  assign clr_boot = wr_sts2 && wdata[B_BOOT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= DATA_W'(RST_INIT);
      halt_q <= 1'b1;
      nrb_q  <= 1'b1;
    end else begin
      if (wr_init && init_ok(32'(wdata[CNT_W-1:0]), MIN_INIT))
        init_q <= wdata;
      if (wr_ctl) begin
        halt_q <= wdata[B_HALT];
        nrb_q  <= wdata[B_NRB];
      end
    end
  end

  assign halt     = halt_q;
  assign nrb_eff  = nrb_q | lock;
  assign init_val = init_q[CNT_W-1:0];

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_RELOAD: rdata[CNT_W-1:0] = count;
      A_STS1:   rdata[B_TMO]     = tmo_flag;
      A_STS2: begin
        rdata[B_SEC]  = sec_flag;
        rdata[B_BOOT] = boot_flag;
      end
      A_CTL: begin
        rdata[B_HALT] = halt_q;
        rdata[B_NRB]  = nrb_eff;
      end
      A_INIT:   rdata = init_q;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdog2_count.sv
module wdog2_count
  import wdog2_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int RST_INIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             go,
  input  logic [CNT_W-1:0] start,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign expire = go && !reload && (cnt_q == '0);
  assign cnt_d  = CNT_W'(count_step(32'(cnt_q), 32'(start), reload, go));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= CNT_W'(RST_INIT);
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/wdog2_stage.sv
module wdog2_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_src,
  input  logic expire,
  input  logic nrb_eff,
  input  logic clr_tmo,
  input  logic clr_sec,
  input  logic clr_boot,
  output logic tmo_flag,
  output logic sec_flag,
  output logic boot_flag,
  output logic irq,
  output logic rst_req
);

  logic first_hit, second_hit;

  assign first_hit  = expire && !tmo_flag;
  assign second_hit = expire && tmo_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_flag  <= 1'b0;
      sec_flag  <= 1'b0;
      boot_flag <= boot_src;
      irq       <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      tmo_flag  <= expire | (tmo_flag & ~clr_tmo);
      sec_flag  <= second_hit | (sec_flag & ~clr_sec);
      boot_flag <= boot_flag & ~clr_boot;
      irq       <= first_hit;
      rst_req   <= second_hit && !nrb_eff;
    end
  end

endmodule

// File: rtl/wdog2_top.sv
module wdog2_top
  import wdog2_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MIN_INIT = 4,
  parameter int RST_INIT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        boot_src,
  input  logic        noreboot_lock,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        rst_req
);

  logic             halt, nrb_eff, reload_wr;
  logic             clr_tmo, clr_sec, clr_boot;
  logic             tmo_flag, sec_flag, boot_flag;
  logic             expire, tick_go;
  logic [CNT_W-1:0] init_val, count;

  assign tick_go = tick_en && !halt;

  wdog2_cfg #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT), .RST_INIT(RST_INIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .lock(noreboot_lock), .count(count), .tmo_flag(tmo_flag), .sec_flag(sec_flag),
    .boot_flag(boot_flag), .halt(halt), .nrb_eff(nrb_eff), .init_val(init_val),
    .reload_wr(reload_wr), .clr_tmo(clr_tmo), .clr_sec(clr_sec), .clr_boot(clr_boot),
    .rdata(reg_rdata)
  );

  wdog2_count #(.CNT_W(CNT_W), .RST_INIT(RST_INIT)) u_count (
    .clk(clk), .rst_n(rst_n), .reload(reload_wr), .go(tick_go), .start(init_val),
    .count(count), .expire(expire)
  );

  wdog2_stage u_stage (
    .clk(clk), .rst_n(rst_n), .boot_src(boot_src), .expire(expire), .nrb_eff(nrb_eff),
    .clr_tmo(clr_tmo), .clr_sec(clr_sec), .clr_boot(clr_boot), .tmo_flag(tmo_flag),
    .sec_flag(sec_flag), .boot_flag(boot_flag), .irq(irq), .rst_req(rst_req)
  );

endmodule

// File: rtl/wdog2_chk.sv
module wdog2_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             rst_req,
  input logic             tmo_flag,
  input logic             sec_flag,
  input logic             halt,
  input logic             reload_wr,
  input logic [CNT_W-1:0] count,
  input logic             lock,
  input logic             nrb_eff
);

  p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload_wr) |=> $stable(count));

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tmo_flag);

  p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_rst_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (sec_flag && $past(tmo_flag)));

  p_rst_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(nrb_eff));

  p_lock_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> nrb_eff);

endmodule

bind wdog2_top wdog2_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .rst_req(rst_req), .tmo_flag(tmo_flag),
  .sec_flag(sec_flag), .halt(halt), .reload_wr(reload_wr), .count(count),
  .lock(noreboot_lock), .nrb_eff(nrb_eff)
);

// File: tb/sim_wdog2_top.sv
module sim_wdog2_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        boot_src = 1'b0;
  logic        noreboot_lock = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = 5'h00;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic        irq, rst_req;

  int checks = 0;
  int errors = 0;

  localparam logic [4:0] RLD = 5'h00, ST1 = 5'h04, ST2 = 5'h06, CTL = 5'h08, INI = 5'h12;

  always #5 clk = ~clk;

  wdog2_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .boot_src(boot_src),
    .noreboot_lock(noreboot_lock), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_rd(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic apply_reset(input logic boot);
    @(negedge clk);
    boot_src = boot; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    chk_rd("R1 ctl", CTL, 16'h0801);
    chk_rd("R1 init", INI, 16'h0004);
    chk_rd("R1 count", RLD, 16'h0004);
    chk_rd("R1 sts1", ST1, 16'h0000);
    chk_rd("R11 sts2 no boot", ST2, 16'h0000);
  endtask

  task automatic t_init;
    wr(INI, 16'h0003);
    chk_rd("R3 low init ignored", INI, 16'h0004);
    wr(INI, 16'hFC0A);
    chk_rd("R3 init stored", INI, 16'hFC0A);
    wr(RLD, 16'h1234);
    chk_rd("R2 reload", RLD, 16'h000A);
  endtask

  task automatic t_halt;
    tick(3);
    chk_rd("R4 halted no count", RLD, 16'h000A);
    wr(INI, 16'h0007);
    wr(RLD, 16'h0000);
    chk_rd("R5 reload while halted", RLD, 16'h0007);
    tick(2);
    chk_rd("R5 halted after reload", RLD, 16'h0007);
  endtask

  task automatic t_run;
    wr(CTL, 16'h0000);
    chk_rd("R4 halt readback", CTL, 16'h0000);
    tick(3);
    chk_rd("R4 counts down", RLD, 16'h0004);
    repeat (3) @(negedge clk);
    chk_rd("R4 no tick holds", RLD, 16'h0004);
  endtask

  task automatic t_two_stage;
    tick(4);
    chk_rd("R6 at zero", RLD, 16'h0000);
    chk("R6 no irq yet", {15'd0, irq}, 16'h0000);
    tick(1);
    chk("R6 irq", {15'd0, irq}, 16'h0001);
    chk_rd("R6 flag", ST1, 16'h0008);
    chk_rd("R6 reloaded", RLD, 16'h0007);
    @(negedge clk);
    chk("R6 irq one cycle", {15'd0, irq}, 16'h0000);
    tick(7);
    chk("R7 no rst yet", {15'd0, rst_req}, 16'h0000);
    tick(1);
    chk("R7 rst_req", {15'd0, rst_req}, 16'h0001);
    chk_rd("R7 second flag", ST2, 16'h0002);
    chk_rd("R7 reloaded", RLD, 16'h0007);
    @(negedge clk);
    chk("R7 rst one cycle", {15'd0, rst_req}, 16'h0000);
  endtask

  task automatic t_w1c;
    wr(ST2, 16'h0000);
    chk_rd("R10 zero write keeps", ST2, 16'h0002);
    wr(ST2, 16'h0002);
    chk_rd("R10 clear sec", ST2, 16'h0000);
    wr(ST1, 16'h0008);
    chk_rd("R10 clear tmo", ST1, 16'h0000);
  endtask

  task automatic t_noreboot;
    logic seen;
    wr(CTL, 16'h0001);
    wr(RLD, 16'h0000);
    tick(8);
    chk("R8 first irq", {15'd0, irq}, 16'h0001);
    seen = 1'b0;
    @(negedge clk);
    tick_en = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (rst_req) seen = 1'b1;
    end
    tick_en = 1'b0;
    chk("R8 rst suppressed", {15'd0, seen}, 16'h0000);
    chk_rd("R8 second flag set", ST2, 16'h0002);
    wr(ST1, 16'h0008);
    wr(ST2, 16'h0002);
  endtask

  task automatic t_lock;
    noreboot_lock = 1'b1;
    wr(CTL, 16'h0000);
    chk_rd("R9 locked reads 1", CTL, 16'h0001);
    @(negedge clk);
    noreboot_lock = 1'b0;
    chk_rd("R9 unlocked stored", CTL, 16'h0000);
  endtask

  task automatic t_race;
    wr(RLD, 16'h0000);
    tick(2);
    chk_rd("R4 before race", RLD, 16'h0005);
    @(negedge clk);
    tick_en = 1'b1; reg_addr = RLD; reg_wr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b0;
    chk_rd("R12 reload beats tick", RLD, 16'h0007);
    tick(7);
    chk_rd("R10 at zero", RLD, 16'h0000);
    @(negedge clk);
    tick_en = 1'b1; reg_addr = ST1; reg_wdata = 16'h0008; reg_wr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b0;
    chk("R10 irq on race", {15'd0, irq}, 16'h0001);
    chk_rd("R10 set beats clear", ST1, 16'h0008);
    wr(ST1, 16'h0008);
  endtask

  task automatic t_boot;
    apply_reset(1'b1);
    chk_rd("R11 boot flag", ST2, 16'h0004);
    chk_rd("R1 ctl after rereset", CTL, 16'h0801);
    wr(ST2, 16'h0004);
    chk_rd("R11 boot cleared", ST2, 16'h0000);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    apply_reset(1'b0);
    @(negedge clk);
    t_reset;
    t_init;
    t_halt;
    t_run;
    t_two_stage;
    t_w1c;
    t_noreboot;
    t_lock;
    t_race;
    t_boot;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule